// File: doc/BRIEF.md
# Key-Armed Hardware Watchdog

This block is a hardware watchdog for a small microcontroller. It starts out off after reset. Software turns it on by writing a two-byte key to a single write-only service register: first 0x1E, then 0xE1. Once it is on, software cannot turn it off. The same two-byte key, written again, clears a hidden 14-bit counter. That counter advances once per machine-cycle strobe. Software can neither read it nor load it.

If the counter is not cleared in time, it reaches 0x3FFF and the block raises its reset output. The reset output stays high for a fixed number of source clocks: 98 in twelve-clock mode and 49 in six-clock mode. When the pulse ends, the watchdog is back in its off state with the counter at zero. Software must send the key again to re-arm it.

The block sits on the processor's register write bus. It receives the machine-cycle strobe from the timing logic and a mode select from the clocking configuration.

Top module: `key_watchdog`

## Requirements
- R1: After a synchronous reset, `wdt_rst_out` is low and the watchdog is off. While it is off, no number of strobes ever raises `wdt_rst_out`.
- R2: A write of 0x1E to address 0xA6, followed by a write of 0xE1 to 0xA6, turns the watchdog on. The counter starts from zero on the clock edge of the 0xE1 write.
- R3: In the key detector, the only write to 0xA6 that advances the sequence is the expected next key byte. Any other value sent to 0xA6 returns the detector to idle. Examples: an 0xE1 with no 0x1E before it, the pair 0x1E 0x1E 0xE1, and the series 0x1E 0x55 0xE1. None of these completes the key.
- R4: Writes to any address other than 0xA6 leave the key detector and the counter unchanged. A 0x1E, then a write elsewhere, then an 0xE1 still completes the key.
- R5: While the watchdog is on, the counter advances by one only on clock edges where `mcyc_strobe` is high. Cycles without the strobe do not move it.
- R6: The counter reaches 0x3FFF after 16383 strobes following the key. `wdt_rst_out` rises on the next clock edge.
- R7: While the watchdog is on, the full key sequence clears the counter to zero. A fresh 16383 strobes are then needed before overflow.
- R8: The pulse on `wdt_rst_out` lasts exactly 98 clock cycles when `half_clk_mode` is 0 at overflow, and exactly 49 cycles when it is 1.
- R9: Once on, the watchdog stays on until overflow or reset. When an overflow pulse ends, the watchdog is off and the counter is cleared. Strobes after that produce no further pulse until the key is sent again.
- R10: Asserting `rst` during a pulse drops `wdt_rst_out` on the next clock edge and leaves the watchdog off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register write address |
| bus_wdata | input | 8 | Register write data |
| mcyc_strobe | input | 1 | One-cycle strobe per machine cycle |
| half_clk_mode | input | 1 | 1 = six-clock mode (short pulse), 0 = twelve-clock mode |
| wdt_rst_out | output | 1 | Reset pulse driven on overflow |

## Verification
The inline properties are checked on every cycle. They cover four behaviours:
- the enable state never drops except at the end of a pulse;
- the count holds on cycles that have no strobe and no key;
- a pulse holds until its length runs out;
- a rising reset output is always preceded by a full count, and never occurs while the watchdog is off.

Only the bench scenarios can show the rest. Those behaviours are the exact number of strobes to overflow, the two pulse lengths, and the rejection of malformed key sequences. The bench also shows that service postpones overflow, and that the watchdog stays off after a pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 8;

    localparam logic [BUS_DW-1:0] KEY_FIRST  = 8'h1E;
    localparam logic [BUS_DW-1:0] KEY_SECOND = 8'hE1;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_e;

    typedef struct packed {
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_wr_t;

    function automatic int unsigned pick_len(input logic half_mode,
                                             input int unsigned long_len,
                                             input int unsigned short_len);
        return half_mode ? short_len : long_len;
    endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter logic [BUS_AW-1:0] SVC_ADDR = 8'hA6
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  bus_wr_t wr,
    output logic    key_ok
);

    seq_e state_q, state_d;
    logic hit;

    assign hit = wr.we && (wr.addr == SVC_ADDR);

    always_comb begin
        state_d = state_q;
        key_ok  = 1'b0;
        if (hit) begin
            if (state_q == SEQ_IDLE && wr.data == KEY_FIRST) begin
                state_d = SEQ_ARMED;
            end else begin
                state_d = SEQ_IDLE;
                if (state_q == SEQ_ARMED && wr.data == KEY_SECOND) begin
                    key_ok = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R3: a completed key always leaves the detector idle
    p_idle_after_key_r3: assert property (@(posedge clk) disable iff (rst)
        key_ok |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/wdt_core_cnt.sv
module wdt_core_cnt #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_ok,
    input  logic             tick,
    input  logic             pulse_busy,
    input  logic             pulse_done,
    output logic             en_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign fire = en_q && (cnt_q == CNT_MAX) && !pulse_busy;

    always_ff @(posedge clk) begin
        if (rst || pulse_done) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else if (pulse_busy || fire) begin
            en_q  <= en_q;
            cnt_q <= cnt_q;
        end else if (key_ok) begin
            en_q  <= 1'b1;
            cnt_q <= '0;
        end else if (en_q && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: once on, only the end of a pulse turns the watchdog off
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (en_q && !pulse_done) |=> en_q);

    // R5: no strobe, no key, no pulse activity -> the count holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (en_q && !pulse_busy && !pulse_done && !key_ok && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse
    import wdt_pkg::*;
#(
    parameter int unsigned LONG_LEN  = 98,
    parameter int unsigned SHORT_LEN = 49
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic half_mode,
    output logic busy,
    output logic done
);

    localparam int unsigned PW_W = $clog2(LONG_LEN + 1);

    logic [PW_W-1:0] rem_q;

    assign done = busy && (rem_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            rem_q <= '0;
        end else if (busy) begin
            if (rem_q == '0) begin
                busy <= 1'b0;
            end else begin
                rem_q <= rem_q - 1'b1;
            end
        end else if (fire) begin
            busy  <= 1'b1;
            rem_q <= PW_W'(pick_len(half_mode, LONG_LEN, SHORT_LEN) - 1);
        end
    end

    // R8: a running pulse holds until its length is used up
    p_hold_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned       CNT_W     = 14,
    parameter logic [BUS_AW-1:0] SVC_ADDR  = 8'hA6,
    parameter int unsigned       LONG_LEN  = 98,
    parameter int unsigned       SHORT_LEN = 49
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              mcyc_strobe,
    input  logic              half_clk_mode,
    output logic              wdt_rst_out
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    bus_wr_t          wr;
    logic             key_ok;
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fire;
    logic             busy;
    logic             done;

    assign wr = '{we: bus_we, addr: bus_addr, data: bus_wdata};

    wdt_key_seq #(.SVC_ADDR(SVC_ADDR)) u_key (
        .clk    (clk),
        .rst    (rst),
        .flush  (done),
        .wr     (wr),
        .key_ok (key_ok)
    );

    wdt_core_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .key_ok     (key_ok),
        .tick       (mcyc_strobe),
        .pulse_busy (busy),
        .pulse_done (done),
        .en_q       (en_q),
        .cnt_q      (cnt_q),
        .fire       (fire)
    );

    wdt_rst_pulse #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .half_mode (half_clk_mode),
        .busy      (busy),
        .done      (done)
    );

    assign wdt_rst_out = busy;

    // R6: the reset output only rises after the counter was full
    p_rise_after_full_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst_out) |-> ($past(cnt_q) == CNT_MAX));

    // R1: while off, the next cycle never starts a pulse
    p_off_no_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !$rose(wdt_rst_out));

endmodule

// File: tb/key_watchdog_tb.sv
module key_watchdog_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       mcyc_strobe = 1'b0;
    logic       half_clk_mode = 1'b0;
    logic       wdt_rst_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int rises  = 0;
    logic prev_out = 1'b0;

    always #5 clk = ~clk;

    key_watchdog u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .mcyc_strobe   (mcyc_strobe),
        .half_clk_mode (half_clk_mode),
        .wdt_rst_out   (wdt_rst_out)
    );

    // behavioural reference model
    int m_on = 0, m_cnt = 0, m_armed = 0, m_busy = 0, m_left = 0;

    always @(posedge clk) begin
        int n_on, n_cnt, n_armed, n_busy, n_left, fin, kok, hit;
        cycles = cycles + 1;
        if (rst) begin
            m_on = 0; m_cnt = 0; m_armed = 0; m_busy = 0; m_left = 0;
        end else begin
            hit = (bus_we && bus_addr == 8'hA6) ? 1 : 0;
            kok = (hit && m_armed && bus_wdata == 8'hE1) ? 1 : 0;
            fin = (m_busy && m_left == 0) ? 1 : 0;
            n_on = m_on; n_cnt = m_cnt; n_armed = m_armed;
            n_busy = m_busy; n_left = m_left;
            if (m_busy) begin
                if (m_left == 0) n_busy = 0;
                else n_left = m_left - 1;
            end else if (m_on && m_cnt == 16383) begin
                n_busy = 1;
                n_left = half_clk_mode ? 48 : 97;
            end
            if (fin) begin
                n_on = 0; n_cnt = 0;
            end else if (m_busy || (m_on && m_cnt == 16383)) begin
                n_cnt = m_cnt;
            end else if (kok) begin
                n_on = 1; n_cnt = 0;
            end else if (m_on && mcyc_strobe) begin
                n_cnt = m_cnt + 1;
            end
            if (fin) n_armed = 0;
            else if (hit) n_armed = (!m_armed && bus_wdata == 8'h1E) ? 1 : 0;
            m_on = n_on; m_cnt = n_cnt; m_armed = n_armed;
            m_busy = n_busy; m_left = n_left;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        checks = checks + 1;
        if (wdt_rst_out !== (m_busy != 0)) begin
            errors = errors + 1;
            $display("FAIL R6/R8 model compare cycle %0d: actual=%b expected=%0d",
                     cycles, wdt_rst_out, m_busy);
        end
        if (wdt_rst_out === 1'b1 && prev_out === 1'b0) rises = rises + 1;
        prev_out = wdt_rst_out;
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input int n, input logic s);
        mcyc_strobe = s;
        repeat (n) @(negedge clk);
        mcyc_strobe = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic measure(input int exp, input string tag);
        int w = 0;
        while (wdt_rst_out === 1'b1 && w < 200) begin
            w = w + 1;
            @(negedge clk);
        end
        chk_int(w, exp, tag);
    endtask

    initial begin
        int r0;
        @(negedge clk);
        do_reset();
        chk(wdt_rst_out, 1'b0, "R1 reset state");

        // R3: malformed keys; R1: off, strobes do nothing
        wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
        r0 = rises;
        run(16500, 1'b1);
        chk_int(rises - r0, 0, "R3 malformed keys leave watchdog off");
        chk(wdt_rst_out, 1'b0, "R1 no pulse while off");

        // R4 + R2 + R6 + R8 long pulse
        wr(8'hA6, 8'h1E); wr(8'h10, 8'hE1); wr(8'hA6, 8'hE1);
        run(16383, 1'b1);
        chk(wdt_rst_out, 1'b0, "R6 low at count 0x3FFF");
        run(1, 1'b0);
        chk(wdt_rst_out, 1'b1, "R4 R2 R6 rises one edge after full count");
        measure(98, "R8 twelve-clock pulse width");

        // R9: off after pulse
        r0 = rises;
        run(16600, 1'b1);
        chk_int(rises - r0, 0, "R9 no pulse after overflow without key");

        // R7 service, then R8 short pulse
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        run(10000, 1'b1);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        half_clk_mode = 1'b1;
        run(16383, 1'b1);
        chk(wdt_rst_out, 1'b0, "R7 service restarts the count");
        run(1, 1'b0);
        chk(wdt_rst_out, 1'b1, "R7 overflow after fresh full count");
        measure(49, "R8 six-clock pulse width");
        half_clk_mode = 1'b0;

        // R5: gaps without strobe do not advance
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        run(8000, 1'b1);
        run(5000, 1'b0);
        run(8383, 1'b1);
        chk(wdt_rst_out, 1'b0, "R5 idle cycles do not count");
        run(1, 1'b0);
        chk(wdt_rst_out, 1'b1, "R5 overflow after 16383 strobes");

        // R10: reset in mid pulse
        run(10, 1'b0);
        chk(wdt_rst_out, 1'b1, "R10 pulse still high before reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(wdt_rst_out, 1'b0, "R10 reset drops pulse");
        r0 = rises;
        run(300, 1'b1);
        chk_int(rises - r0, 0, "R10 watchdog off after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog timeout: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule